// File: doc/BRIEF.md
# Asynchronous Loopback Pattern Error Checker

This block measures the bit error count at a single jitter-tolerance test point. It receives the symbol stream that a device under test sends back in loopback, as 8-bit symbols with a K (control) flag. The block produces a scrambled all-zero data pattern locally and compares the received stream against it bit by bit. The device may add or drop clock-compensation (SKP) symbols at any point. The checker removes these from the stream before it compares anything, so the generator and the checker do not need a common reference clock.

A comma (COM) symbol in the received stream reseeds the local scrambler, and this is how the reference lines up with the data. Two things must both be true before bits and errors are counted. First, a run has been opened with a start pulse. Second, the checker has locked onto the stream. When the number of compared bits reaches the budget for the point (3×10^10 by default, the shortened test for a 10^-12 error-rate goal), the block raises a one-cycle done pulse. At the same moment it sets a pass flag: the point passes when the error count is no more than one.

Top module: `loopback_err_checker`

## Requirements
- R1: After reset, `locked`, `done` and `pass` are 0, and `bit_count` and `err_count` are 0.
- R2: A symbol with K=1 and value 0x3C (SKP) is dropped. It is not compared, it does not advance the reference, and it changes no count or lock state.
- R3: A symbol with K=1 and value 0xBC (COM) is not compared. It reseeds the reference LFSR to 0xFFFF.
- R4: Every other valid symbol is compared, data byte only, against the reference byte. Bit i of the reference byte (i = 0 first, the LSB) is LFSR bit 15 before step i. One step shifts the LFSR left by one and, if the old bit 15 was 1, XORs the result with 0x0039. This gives polynomial x^16+x^5+x^4+x^3+1. The LFSR takes 8 steps for each compared symbol.
- R5: While unlocked, `locked` rises once LOCK_RUN (default 8) consecutive compared symbols have matched.
- R6: While locked, `locked` falls once UNLOCK_RUN (default 8) consecutive compared symbols have mismatched.
- R7: A compared symbol that arrives during a run while the checker is already locked adds 8 to `bit_count` and adds its number of differing bits to `err_count`. A compared symbol that arrives while the checker is unlocked adds nothing. The symbol that completes a lock run therefore adds nothing. A symbol affects the outputs after the second rising clock edge that follows its arrival.
- R8: `err_count` saturates at its all-ones value and does not wrap.
- R9: A `start` pulse clears `bit_count`, `err_count` and `pass`, and opens a run. No counting takes place before the first start.
- R10: When `bit_count` reaches BIT_TARGET, which must be a multiple of 8, `done` pulses for one cycle. `pass` becomes 1 if `err_count` ≤ ERR_LIMIT (default 1) and 0 otherwise. The run then closes, and the counts hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears counters and opens a test point |
| sym_valid | input | 1 | A received symbol is present |
| sym_data | input | 8 | Received symbol value |
| sym_k | input | 1 | Received symbol is a control symbol |
| locked | output | 1 | Reference is aligned with the stream |
| bit_count | output | BITW (35 by default) | Compared bits in the current point |
| err_count | output | ERRW | Bit errors in the current point, saturating |
| done | output | 1 | One-cycle pulse when the bit budget is reached |
| pass | output | 1 | Verdict of the last completed point |

## Verification
The checker is tried with clean scrambled streams that have random SKP symbols and extra COM symbols scattered through them. These show that SKP is dropped and that COM reseeds the reference rather than being counted. Streams carrying one or two single-bit flips tell the pass verdict apart from the fail verdict at the threshold. Bursts of wholly corrupted symbols test saturation and the unlock rule. Random flips placed before lock is reached show that errors are counted only while locked. Streams sent after done show that the counts are frozen.

// File: rtl/lbchk_pkg.sv
package lbchk_pkg;
  localparam logic [7:0] SYM_SKP = 8'h3C;
  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [15:0] LFSR_SEED = 16'hFFFF;
  localparam logic [15:0] LFSR_TAPS = 16'h0039;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/lbchk_sym_filter.sv
module lbchk_sym_filter
  import lbchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_k,
  output logic       cmp_v,
  output logic       com_v,
  output logic [7:0] cmp_byte
);
  logic is_skp, is_com;
  assign is_skp = in_k && (in_data == SYM_SKP);
  assign is_com = in_k && (in_data == SYM_COM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_v    <= 1'b0;
      com_v    <= 1'b0;
      cmp_byte <= '0;
    end else begin
      cmp_v    <= in_valid && !is_skp && !is_com;
      com_v    <= in_valid && is_com;
      cmp_byte <= in_data;
    end
  end

  // R2
  skp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_k && in_data == SYM_SKP) |=> (!cmp_v && !com_v));
endmodule

// File: rtl/lbchk_ref_scrambler.sv
module lbchk_ref_scrambler
  import lbchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reseed,
  input  logic       advance,
  output logic [7:0] ref_byte
);
  logic [15:0] state_q, state_nx;

  always_comb begin
    logic [15:0] s;
    s = state_q;
    ref_byte = '0;
    for (int i = 0; i < 8; i++) begin
      ref_byte[i] = s[15];
      s = {s[14:0], 1'b0} ^ (s[15] ? LFSR_TAPS : 16'h0000);
    end
    state_nx = s;
  end

  always_ff @(posedge clk) begin
    if (rst || reseed) state_q <= LFSR_SEED;
    else if (advance)  state_q <= state_nx;
  end

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reseed && !advance) |=> $stable(ref_byte));
endmodule

// File: rtl/lbchk_lock_ctrl.sv
module lbchk_lock_ctrl #(
  parameter int LOCK_RUN   = 8,
  parameter int UNLOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_v,
  input  logic cmp_match,
  output logic locked
);
  localparam int MAXRUN = (LOCK_RUN > UNLOCK_RUN) ? LOCK_RUN : UNLOCK_RUN;
  localparam int RUNW   = $clog2(MAXRUN + 1);
  localparam logic [RUNW-1:0] GOOD_LAST = RUNW'(LOCK_RUN - 1);
  localparam logic [RUNW-1:0] BAD_LAST  = RUNW'(UNLOCK_RUN - 1);

  logic [RUNW-1:0] good_run, bad_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_run <= '0;
      bad_run  <= '0;
      locked   <= 1'b0;
    end else if (cmp_v) begin
      if (cmp_match) begin
        bad_run <= '0;
        if (good_run != GOOD_LAST) good_run <= good_run + 1'b1;
        if (!locked && good_run == GOOD_LAST) locked <= 1'b1;
      end else begin
        good_run <= '0;
        if (bad_run != BAD_LAST) bad_run <= bad_run + 1'b1;
        if (locked && bad_run == BAD_LAST) locked <= 1'b0;
      end
    end
  end

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cmp_v && cmp_match));
  // R6
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(cmp_v && !cmp_match));
endmodule

// File: rtl/lbchk_counters.sv
module lbchk_counters #(
  parameter longint unsigned BIT_TARGET = 64'd30_000_000_000,
  parameter int BITW      = 35,
  parameter int ERRW      = 16,
  parameter int ERR_LIMIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            cmp_v,
  input  logic            locked,
  input  logic [3:0]      miss_bits,
  output logic [BITW-1:0] bit_cnt,
  output logic [ERRW-1:0] err_cnt,
  output logic            done,
  output logic            pass
);
  localparam logic [BITW:0]   TGT_EXT = {1'b0, BIT_TARGET[BITW-1:0]};
  localparam logic [ERRW-1:0] ERR_MAX = '1;
  localparam logic [ERRW-1:0] LIMIT   = ERRW'(ERR_LIMIT);

  logic            running;
  logic [BITW:0]   bit_nx;
  logic [ERRW:0]   err_sum;
  logic [ERRW-1:0] err_nx;
  logic            count_en;

  assign count_en = running && cmp_v && locked;
  assign bit_nx   = {1'b0, bit_cnt} + (BITW+1)'(8);
  assign err_sum  = {1'b0, err_cnt} + (ERRW+1)'(miss_bits);
  assign err_nx   = err_sum[ERRW] ? ERR_MAX : err_sum[ERRW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      err_cnt <= '0;
      running <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        bit_cnt <= '0;
        err_cnt <= '0;
        pass    <= 1'b0;
        running <= 1'b1;
      end else if (count_en) begin
        bit_cnt <= bit_nx[BITW-1:0];
        err_cnt <= err_nx;
        if (bit_nx >= TGT_EXT) begin
          done    <= 1'b1;
          pass    <= (err_nx <= LIMIT);
          running <= 1'b0;
        end
      end
    end
  end

  // R8
  err_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> err_cnt >= $past(err_cnt));
  // R7
  bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + BITW'(8)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !count_en) |=> ($stable(bit_cnt) && $stable(err_cnt)));
  // R10
  bit_cap_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, bit_cnt} <= TGT_EXT);
  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ({1'b0, bit_cnt} == TGT_EXT && !running));
endmodule

// File: rtl/loopback_err_checker.sv
module loopback_err_checker
  import lbchk_pkg::*;
#(
  parameter longint unsigned BIT_TARGET = 64'd30_000_000_000,
  parameter int ERRW       = 16,
  parameter int ERR_LIMIT  = 1,
  parameter int LOCK_RUN   = 8,
  parameter int UNLOCK_RUN = 8,
  localparam int BITW      = $clog2(BIT_TARGET + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            sym_valid,
  input  logic [7:0]      sym_data,
  input  logic            sym_k,
  output logic            locked,
  output logic [BITW-1:0] bit_count,
  output logic [ERRW-1:0] err_count,
  output logic            done,
  output logic            pass
);
  logic       cmp_v, com_v;
  logic [7:0] cmp_byte, ref_byte, diff;

  lbchk_sym_filter u_filt (
    .clk(clk), .rst(rst), .in_valid(sym_valid), .in_data(sym_data), .in_k(sym_k),
    .cmp_v(cmp_v), .com_v(com_v), .cmp_byte(cmp_byte)
  );

  lbchk_ref_scrambler u_scr (
    .clk(clk), .rst(rst), .reseed(com_v), .advance(cmp_v), .ref_byte(ref_byte)
  );

  assign diff = cmp_byte ^ ref_byte;

  lbchk_lock_ctrl #(.LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
    .clk(clk), .rst(rst), .cmp_v(cmp_v), .cmp_match(diff == 8'h00), .locked(locked)
  );

  lbchk_counters #(
    .BIT_TARGET(BIT_TARGET), .BITW(BITW), .ERRW(ERRW), .ERR_LIMIT(ERR_LIMIT)
  ) u_cnt (
    .clk(clk), .rst(rst), .start(start), .cmp_v(cmp_v), .locked(locked),
    .miss_bits(ones8(diff)), .bit_cnt(bit_count), .err_cnt(err_count),
    .done(done), .pass(pass)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!locked && bit_count == '0 && err_count == '0 && !done && !pass));
endmodule

// File: tb/sim_loopback_err_checker.sv
module sim_loopback_err_checker;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned TGT = 800;
  localparam int EW = 4;
  localparam int LIM = 1;
  localparam int BW = $clog2(TGT + 1);

  logic clk = 0, rst = 1, start = 0, sym_valid = 0, sym_k = 0;
  logic [7:0] sym_data = 0;
  logic locked, done, pass;
  logic [BW-1:0] bit_count;
  logic [EW-1:0] err_count;

  int n_tests = 0, n_fail = 0;
  bit seen_done = 0;

  // bench model state
  logic [15:0] m_lfsr = 16'hFFFF;
  bit m_locked = 0, m_run = 0, m_pass = 0;
  int m_good = 0, m_bad = 0;
  longint m_bits = 0;
  int m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopback_err_checker #(.BIT_TARGET(TGT), .ERRW(EW), .ERR_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .start(start), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_k(sym_k), .locked(locked), .bit_count(bit_count), .err_count(err_count),
    .done(done), .pass(pass)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(negedge clk) if (done) seen_done = 1;

  function automatic logic [7:0] ref_next();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      b[i] = m_lfsr[15];
      m_lfsr = {m_lfsr[14:0], 1'b0} ^ (m_lfsr[15] ? 16'h0039 : 16'h0000);
    end
    return b;
  endfunction

  function automatic int nbits(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic k);
    @(negedge clk);
    sym_valid = 1; sym_data = d; sym_k = k;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    sym_valid = 0; sym_k = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_skp();
    put(8'h3C, 1'b1);
  endtask

  task automatic send_com();
    put(8'hBC, 1'b1);
    m_lfsr = 16'hFFFF;
  endtask

  // one data symbol with given flip mask, model updated per R4..R10
  task automatic send_data(input logic [7:0] flip);
    logic [7:0] e;
    int mm;
    e = ref_next();
    mm = nbits(flip);
    put(e ^ flip, 1'b0);
    if (m_run && m_locked) begin
      m_bits += 8;
      m_err = (m_err + mm > (1 << EW) - 1) ? (1 << EW) - 1 : m_err + mm;
      if (m_bits >= TGT) begin m_run = 0; m_pass = (m_err <= LIM); end
    end
    if (mm == 0) begin
      m_bad = 0; m_good++;
      if (!m_locked && m_good >= 8) m_locked = 1;
    end else begin
      m_good = 0; m_bad++;
      if (m_locked && m_bad >= 8) m_locked = 0;
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    sym_valid = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    m_run = 1; m_bits = 0; m_err = 0; m_pass = 0; seen_done = 0;
  endtask

  task automatic clean_stream(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) == 0) send_skp();
      send_data(8'h00);
    end
  endtask

  task automatic compare_all(input string req);
    idle(3);
    check({req, " locked"}, locked, m_locked);
    check({req, " bit_count"}, bit_count, m_bits);
    check({req, " err_count"}, err_count, m_err);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 locked", locked, 0);
    check("R1 bit_count", bit_count, 0);
    check("R1 err_count", err_count, 0);
    check("R1 pass", pass, 0);

    // R9: nothing counted before the first start; R5 lock forms anyway
    send_com();
    clean_stream(12);
    compare_all("R9 pre-start");

    // R2/R3/R4/R5/R7: clean stream with SKP and extra COM
    do_start();
    send_com();
    clean_stream(15);
    send_com();
    send_skp(); send_skp();
    clean_stream(10);
    compare_all("R2 R3 R4 clean");

    // R7: single bit error
    send_data(8'h01 << $urandom_range(7));
    clean_stream(5);
    compare_all("R7 single");

    // R10: run to budget, one error -> pass
    while (m_run) send_data(8'h00);
    idle(3);
    check("R10 done seen", seen_done, 1);
    check("R10 pass one err", pass, 1);
    check("R10 bit_count", bit_count, TGT);
    clean_stream(6);
    compare_all("R10 frozen after done");

    // R9: start clears
    do_start();
    idle(1);
    check("R9 bit_count clr", bit_count, 0);
    check("R9 err_count clr", err_count, 0);
    check("R9 pass clr", pass, 0);

    // R10: two errors -> fail
    send_data(8'h10);
    clean_stream(3);
    send_data(8'h80);
    while (m_run) send_data(8'h00);
    idle(3);
    check("R10 done two", seen_done, 1);
    check("R10 pass two err", pass, 0);
    check("R10 err two", err_count, 2);

    // R6 unlock, then errors while unlocked ignored, then relock R5
    do_start();
    for (int i = 0; i < 8; i++) send_data(8'hFF);
    compare_all("R6 unlock");
    check("R6 locked low", locked, 0);
    for (int i = 0; i < 5; i++) send_data(8'($urandom_range(255)) | 8'h01);
    compare_all("R7 unlocked ignored");
    clean_stream(8);
    compare_all("R5 relock");
    check("R5 locked high", locked, 1);

    // R8 saturation: alternate full-flip and clean symbols
    for (int i = 0; i < 6; i++) begin send_data(8'hFF); send_data(8'h00); end
    compare_all("R8 saturate");
    check("R8 err max", err_count, (1 << EW) - 1);

    // random segments
    for (int s = 0; s < 4; s++) begin
      do_start();
      send_com();
      for (int i = 0; i < 40; i++) begin
        if ($urandom_range(4) == 0) send_skp();
        if ($urandom_range(15) == 0) send_data(8'($urandom_range(255)));
        else send_data(8'h00);
      end
      compare_all("R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule